// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures the frequency of an external digital signal. A start pulse opens a gate that lasts a programmable number of milliseconds. The gate is timed from the system clock by a prescaler followed by a compare-and-clear timebase counter. While the gate is open, rising edges of the synchronized input are counted. The count is held in a narrow edge counter, and a separate overflow counter extends its range.

When the gate closes, counting stops. Any edge-counter overflow that has not yet been added in is folded into the total. A bit-serial restoring divider then computes count × 1000 / gate length, which gives the result in hertz. The ready flag drops as soon as a measurement starts. It rises again once the new result has been captured. A start pulse that arrives during a measurement is ignored.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset, `ready` is 0 and `freqHz` is 0.
- R2: A start accepted while idle clears `ready`, and this is visible in the cycle after the start edge. `ready` stays low until the new result is in `freqHz`.
- R3: One millisecond lasts T = PRESCALE × (TB_TOP + 1) clock cycles. For a gate of g ms, `ready` rises exactly g·T + (EDGE_W + OVF_W + 10) + 1 clock edges after the edge that accepted the start.
- R4: `freqHz` = floor(count × 1000 / g). Here count is the number of synchronized rising edges detected in the g·T − 1 cycles that follow the start edge. For a periodic input of period P cycles, count is floor((g·T−1)/P) or ceil((g·T−1)/P).
- R5: Counts beyond 2^EDGE_W are carried into the overflow counter. This includes a wrap that is still pending when the gate closes, so the total equals overflows × 2^EDGE_W + edge count.
- R6: A gate length of 0 is measured as a gate of 1 ms, for both timing and scaling.
- R7: A start pulse during a measurement is ignored. The gate length is latched when the start is accepted, so later changes to `gateMs` have no effect on that measurement.
- R8: `freqHz` keeps the previous result throughout a new measurement until the new result is captured.
- R9: The input passes through a two-flip-flop synchronizer before edge detection. An input that does not toggle gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigIn | input | 1 | Asynchronous signal under test |
| start | input | 1 | Start pulse, accepted only while idle |
| gateMs | input | MS_W | Gate length in milliseconds (0 means 1) |
| freqHz | output | RES_W | Last measured frequency in hertz |
| ready | output | 1 | High while `freqHz` holds a completed result and no measurement is running |

## Verification
The bench drives start before a clock edge and counts edges from that one. It checks that `ready` is already low in the cycle after that edge. It also checks that `ready` rises exactly g·T + CNT_W + 11 edges later, where CNT_W + 10 is the divider length. Because the input toggles on falling clock edges with a known half period, the count in the g·T − 1 cycle window is one of two neighbouring integers, and the result must equal one of the two scaled values. Every sample is taken at a falling edge, so it always falls after the register that produced it.

// File: rtl/fc_pkg.sv
package fc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // reset counters, latch gate length
    logic run;       // gate open
    logic divStart;  // gate closes this cycle, load divider
    logic capture;   // divider finished, store result
  } fcStrobe_t;
endpackage

// File: rtl/fc_divider.sv
module fc_divider #(
  parameter int NUM_W = 42,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quot,
  output logic             done
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0]  quoR;
  logic [DEN_W-1:0]  remR;
  logic [STEP_W-1:0] stepR;
  logic              busyR;
  logic              doneR;

  logic [DEN_W:0] shifted;
  logic [DEN_W:0] trial;
  logic           noBorrow;

  always_comb begin
    shifted  = {remR, quoR[NUM_W-1]};
    trial    = shifted - {1'b0, den};
    noBorrow = shifted >= {1'b0, den};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoR  <= '0;
      remR  <= '0;
      stepR <= '0;
      busyR <= 1'b0;
      doneR <= 1'b0;
    end else if (load) begin
      quoR  <= num;
      remR  <= '0;
      stepR <= '0;
      busyR <= 1'b1;
      doneR <= 1'b0;
    end else if (busyR) begin
      quoR  <= {quoR[NUM_W-2:0], noBorrow};
      remR  <= noBorrow ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
      stepR <= stepR + 1'b1;
      if (stepR == STEP_W'(NUM_W - 1)) begin
        busyR <= 1'b0;
        doneR <= 1'b1;
      end
    end else begin
      doneR <= 1'b0;
    end
  end

  assign quot = quoR;
  assign done = doneR;

  // R4: divider finishes with a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);
  // R4: step counter never passes the numerator width
  a_r4_step_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyR |-> stepR < STEP_W'(NUM_W));
  // R4: partial remainder stays below the divisor
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyR |-> remR < den);
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      gateClose,
  input  logic      divDone,
  output fcStrobe_t strb,
  output logic      ready
);
  typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_DIV} fcState_t;

  fcState_t stateR;
  logic     readyR;

  always_comb begin
    strb = '0;
    unique case (stateR)
      ST_IDLE:  strb.clear = start;
      ST_COUNT: begin
        strb.run      = 1'b1;
        strb.divStart = gateClose;
      end
      ST_DIV:   strb.capture = divDone;
      default:  strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      readyR <= 1'b0;
    end else begin
      unique case (stateR)
        ST_IDLE: if (start) begin
          stateR <= ST_COUNT;
          readyR <= 1'b0;
        end
        ST_COUNT: if (gateClose) stateR <= ST_DIV;
        ST_DIV: if (divDone) begin
          stateR <= ST_IDLE;
          readyR <= 1'b1;
        end
        default: stateR <= ST_IDLE;
      endcase
    end
  end

  assign ready = readyR;

  // R2: ready is never high while a measurement is running
  a_r2_ready_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    stateR != ST_IDLE |-> !readyR);
  // R7: while the gate is open, only its close leaves the count state
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == ST_COUNT && !gateClose) |=> stateR == ST_COUNT);
  // R3: gate close hands over to the divider
  a_r3_close_to_div: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == ST_COUNT && gateClose) |=> stateR == ST_DIV);
endmodule

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
#(
  parameter int PRESCALE  = 128,
  parameter int TB_TOP    = 124,
  parameter int EDGE_W    = 16,
  parameter int OVF_W     = 16,
  parameter int MS_W      = 16,
  parameter int RES_W     = 32,
  parameter int HZ_PER_MS = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic [MS_W-1:0]  gateMs,
  input  fcStrobe_t        strb,
  output logic             gateClose,
  output logic             divDone,
  output logic [RES_W-1:0] result
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TB_W  = (TB_TOP > 0) ? $clog2(TB_TOP + 1) : 1;
  localparam int CNT_W = EDGE_W + OVF_W;
  localparam int NUM_W = CNT_W + 10;
  localparam logic [NUM_W-1:0] HZ_SCALE = NUM_W'(HZ_PER_MS);

  // input synchronizer and rising-edge detect
  logic [2:0] syncQ;
  logic       rise;
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], sigIn};
  end
  assign rise = syncQ[1] & ~syncQ[2];

  // millisecond timebase
  logic [PRE_W-1:0] preCnt;
  logic [TB_W-1:0]  tbCnt;
  logic [MS_W-1:0]  tickCnt;
  logic [MS_W-1:0]  gateEff;
  logic             preWrap;
  logic             msPulse;

  assign preWrap   = strb.run && (preCnt == PRE_W'(PRESCALE - 1));
  assign msPulse   = preWrap && (tbCnt == TB_W'(TB_TOP));
  assign gateClose = msPulse && (({1'b0, tickCnt} + 1'b1) >= {1'b0, gateEff});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      tbCnt   <= '0;
      tickCnt <= '0;
      gateEff <= MS_W'(1);
    end else if (strb.clear) begin
      preCnt  <= '0;
      tbCnt   <= '0;
      tickCnt <= '0;
      gateEff <= (gateMs == '0) ? MS_W'(1) : gateMs;
    end else if (strb.run) begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
      if (preWrap) tbCnt <= msPulse ? '0 : tbCnt + 1'b1;
      if (msPulse && !gateClose) tickCnt <= tickCnt + 1'b1;
    end
  end

  // edge counter with overflow extension
  logic [EDGE_W-1:0] edgeCnt;
  logic [OVF_W-1:0]  ovfCnt;
  logic              ovfPend;
  logic              countEdge;
  logic              wrapNow;

  assign countEdge = strb.run && rise && !gateClose;
  assign wrapNow   = countEdge && (&edgeCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt <= '0;
      ovfCnt  <= '0;
      ovfPend <= 1'b0;
    end else if (strb.clear || strb.divStart) begin
      if (strb.clear) edgeCnt <= '0;
      ovfCnt  <= '0;
      ovfPend <= 1'b0;
    end else if (strb.run) begin
      if (countEdge) edgeCnt <= edgeCnt + 1'b1;
      if (ovfPend) ovfCnt <= ovfCnt + 1'b1;
      ovfPend <= wrapNow;
    end
  end

  // total with any pending wrap folded in, scaled to hertz numerator
  logic [CNT_W-1:0] total;
  logic [NUM_W-1:0] numer;
  logic [NUM_W-1:0] quot;
  assign total = {ovfCnt + OVF_W'(ovfPend), edgeCnt};
  assign numer = NUM_W'(total) * HZ_SCALE;

  fc_divider #(.NUM_W(NUM_W), .DEN_W(MS_W)) i_div (
    .clk  (clk),
    .rstN (rstN),
    .load (strb.divStart),
    .num  (numer),
    .den  (gateEff),
    .quot (quot),
    .done (divDone)
  );

  always_ff @(posedge clk) begin
    if (!rstN)             result <= '0;
    else if (strb.capture) result <= RES_W'(quot);
  end

  // R3: timebase counter never exceeds its compare value
  a_r3_tb_range: assert property (@(posedge clk) disable iff (!rstN)
    tbCnt <= TB_W'(TB_TOP));
  // R3: elapsed ticks stay below the latched gate while counting
  a_r3_tick_bound: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> tickCnt < gateEff);
  // R6: latched gate length is never zero
  a_r6_gate_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    gateEff != '0);
  // R5: a pending wrap is added to the overflow count one cycle later
  a_r5_ovf_fold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && ovfPend && !gateClose) |=> ovfCnt == $past(ovfCnt) + 1'b1);
  // R4: edge count frozen outside the gate
  a_r4_edge_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clear) |=> $stable(edgeCnt));
  // R8: result changes only on capture
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(result));
endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter
  import fc_pkg::*;
#(
  parameter int PRESCALE  = 128,
  parameter int TB_TOP    = 124,
  parameter int EDGE_W    = 16,
  parameter int OVF_W     = 16,
  parameter int MS_W      = 16,
  parameter int RES_W     = 32,
  parameter int HZ_PER_MS = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic             start,
  input  logic [MS_W-1:0]  gateMs,
  output logic [RES_W-1:0] freqHz,
  output logic             ready
);
  fcStrobe_t strb;
  logic      gateClose;
  logic      divDone;

  fc_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .gateClose (gateClose),
    .divDone   (divDone),
    .strb      (strb),
    .ready     (ready)
  );

  fc_datapath #(
    .PRESCALE  (PRESCALE),
    .TB_TOP    (TB_TOP),
    .EDGE_W    (EDGE_W),
    .OVF_W     (OVF_W),
    .MS_W      (MS_W),
    .RES_W     (RES_W),
    .HZ_PER_MS (HZ_PER_MS)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sigIn     (sigIn),
    .gateMs    (gateMs),
    .strb      (strb),
    .gateClose (gateClose),
    .divDone   (divDone),
    .result    (freqHz)
  );
endmodule

// File: tb/test_gated_freq_counter.sv
module test_gated_freq_counter;
  localparam int PRESCALE = 2;
  localparam int TB_TOP   = 4;
  localparam int EDGE_W   = 4;
  localparam int OVF_W    = 4;
  localparam int MS_W     = 4;
  localparam int RES_W    = 32;
  localparam int T_MS     = PRESCALE * (TB_TOP + 1);
  localparam int DIV_LEN  = EDGE_W + OVF_W + 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            sigIn = 1'b0;
  logic            start = 1'b0;
  logic [MS_W-1:0] gateMs = '0;
  logic [RES_W-1:0] freqHz;
  logic            ready;

  int errors = 0;
  int checks = 0;
  int halfP  = 0;
  int tgl    = 0;

  always #2.5 clk = ~clk;

  gated_freq_counter #(
    .PRESCALE(PRESCALE), .TB_TOP(TB_TOP), .EDGE_W(EDGE_W),
    .OVF_W(OVF_W), .MS_W(MS_W), .RES_W(RES_W)
  ) i_gated_freq_counter (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .start(start),
    .gateMs(gateMs), .freqHz(freqHz), .ready(ready)
  );

  // input generator: toggles every halfP cycles on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (halfP != 0) begin
        tgl = tgl + 1;
        if (tgl >= halfP) begin
          sigIn = ~sigIn;
          tgl = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one measurement; optional disturbing start at cycle disturbAt
  task automatic measure(input int g, input int disturbAt, input string req,
                         output int lat, output longint res, output longint mid);
    bit waiting;
    @(negedge clk);
    gateMs = MS_W'(g);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(ready == 1'b0, "R2 ready cleared", longint'(ready), 0);
    lat = 0;
    mid = 0;
    waiting = 1'b1;
    while (waiting) begin
      @(posedge clk);
      lat = lat + 1;
      @(negedge clk);
      if (lat == 5) mid = longint'(freqHz);
      if (disturbAt != 0 && lat == disturbAt) begin
        start = 1'b1;
        gateMs = MS_W'(7);
      end else begin
        start = 1'b0;
      end
      if (ready || lat > 2000) waiting = 1'b0;
    end
    res = longint'(freqHz);
    if (req.len() == 0) lat = lat;
  endtask

  task automatic expectFreq(input int g, input int hp, input longint res, input string req);
    int ge;
    int w;
    int p;
    longint lo;
    longint hi;
    ge = (g == 0) ? 1 : g;
    w = ge * T_MS - 1;
    if (hp == 0) begin
      check(res == 0, req, res, 0);
    end else begin
      p = 2 * hp;
      lo = longint'((w / p) * 1000 / ge);
      hi = longint'(((w + p - 1) / p) * 1000 / ge);
      check(res == lo || res == hi, req, res, lo);
    end
  endtask

  initial begin
    int gList[6];
    int hList[6];
    int lat;
    longint res;
    longint mid;
    longint prev;
    string tag;
    gList = '{0, 1, 2, 3, 6, 15};
    hList = '{0, 1, 2, 3, 5, 7};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ready == 1'b0, "R1 ready after reset", longint'(ready), 0);
    check(freqHz == '0, "R1 result after reset", longint'(freqHz), 0);

    // sweep gate lengths and input periods
    foreach (gList[gi]) begin
      foreach (hList[hi]) begin
        halfP = hList[hi];
        repeat (3) @(negedge clk);
        measure(gList[gi], 0, "sweep", lat, res, mid);
        check(lat == ((gList[gi] == 0) ? 1 : gList[gi]) * T_MS + DIV_LEN + 1,
              (gList[gi] == 0) ? "R6 R3 latency for zero gate" : "R3 ready latency",
              lat, ((gList[gi] == 0) ? 1 : gList[gi]) * T_MS + DIV_LEN + 1);
        if (hList[hi] == 0)                         tag = "R9 steady input";
        else if (gList[gi] == 0)                    tag = "R6 zero gate scaling";
        else if (gList[gi] * T_MS / (2 * hList[hi]) >= 16) tag = "R5 overflow extension";
        else                                        tag = "R4 frequency value";
        expectFreq(gList[gi], hList[hi], res, tag);
        check(ready == 1'b1, "R2 ready after result", longint'(ready), 1);
      end
    end

    // R7: start and gate change during a measurement are ignored
    halfP = 2;
    measure(3, 12, "R7", lat, res, mid);
    check(lat == 3 * T_MS + DIV_LEN + 1, "R7 latency unchanged by extra start", lat, 3 * T_MS + DIV_LEN + 1);
    expectFreq(3, 2, res, "R7 result uses latched gate");
    prev = res;
    repeat (5) @(negedge clk);
    check(ready == 1'b1 && longint'(freqHz) == prev, "R7 no restart after measurement", longint'(freqHz), prev);

    // R8: previous result held during the next measurement
    halfP = 3;
    measure(6, 0, "R8", lat, res, mid);
    check(mid == prev, "R8 result held while busy", mid, prev);
    expectFreq(6, 3, res, "R4 frequency after hold");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule